// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block translates architectural register numbers into physical register tags for a group of up to four instructions each clock cycle. It keeps a mapping table with one physical tag and one ready flag for every architectural register. Unused physical tags wait in a circular queue. Every valid slot in a group takes a fresh tag from the head of that queue. The table is updated so that later groups see the new mapping. The slots of one group are resolved as if they ran one after another, lowest slot first. So a younger slot that reads a register written by an older slot in the same group gets the older slot's new tag, not the table's value.

The stage sits between decode and dispatch. For every renamed slot it reports four values one cycle later:
- the two source tags and their ready flags;
- the newly assigned destination tag;
- the tag that the destination used to map to, so that a later stage can give it back.

Retired tags come back through a release port and are appended to the tail of the queue. A wakeup port takes a physical tag and marks as ready every table entry that currently maps to it. When the queue holds fewer tags than the group needs, the whole group is held off, and nothing in it is renamed.

Top module: `rename_stage`

## Requirements
- R1: After reset, architectural register i maps to physical tag i with its ready flag set. Tags 16 to 127 sit in the queue in ascending order, and `out_valid` is all zero.
- R2: Valid slots take tags from the queue head in ascending slot order. An invalid slot takes no tag and leaves its `out_valid` bit clear.
- R3: A source that no older slot in the same group writes returns the tag and ready flag the table holds. After a group is renamed, the table holds the new mapping for each destination written.
- R4: A source that an older slot in the same group writes returns the new tag of the youngest such older slot, with its ready flag clear.
- R5: When several slots of a group write the same architectural register, the youngest writer's tag is the one left in the table.
- R6: `out_prev_tag` of a slot is the mapping its destination had just before that slot: the table value, or the new tag of an older slot in the same group that wrote the same register.
- R7: A newly written table entry starts with its ready flag clear.
- R8: A wakeup sets the ready flag of every table entry whose tag equals `wake_tag`. A source that reads such an entry in the same cycle already reports ready.
- R9: `stall` is high in the same cycle exactly when the queue holds fewer tags than the number of valid slots. A stalled group changes no mapping and takes no tag.
- R10: Released tags are appended at the queue tail in ascending lane order, and they are handed out after every tag already queued. A release is not available to the group renamed in the same cycle.
- R11: The outputs of a group accepted at clock edge k are valid right after edge k. `out_valid` then equals the group's `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 4 | Slot valid bits, slot 0 oldest |
| in_dst | input | 16 | Destination architectural numbers, 4 bits per slot |
| in_src1 | input | 16 | First source architectural numbers, 4 bits per slot |
| in_src2 | input | 16 | Second source architectural numbers, 4 bits per slot |
| rel_valid | input | 4 | Release lane valid bits |
| rel_tag | input | 28 | Released physical tags, 7 bits per lane |
| wake_valid | input | 1 | Wakeup strobe |
| wake_tag | input | 7 | Physical tag that has become ready |
| stall | output | 1 | Group held off for lack of free tags |
| out_valid | output | 4 | Renamed slot valid bits |
| out_dst_tag | output | 28 | New destination tags |
| out_prev_tag | output | 28 | Replaced destination tags |
| out_src1_tag | output | 28 | First source tags |
| out_src2_tag | output | 28 | Second source tags |
| out_src1_ready | output | 4 | First source ready flags |
| out_src2_ready | output | 4 | Second source ready flags |

## Verification
The hardest state to reach from the ports is a nearly empty queue. That is where the stall threshold and the wrap of the queue pointers meet. The stimulus drains all 112 initial tags with full groups until fewer than four remain. It then asks for one tag more than is left. Next it releases tags on non-adjacent lanes while still stalled. Last, it shows that a group of exactly the right size receives the released tags in lane order.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned ARCH_REGS = 16;
  localparam int unsigned PHYS_REGS = 128;
  localparam int unsigned GROUP_W   = 4;
endpackage

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int ARCH_N  = rename_pkg::ARCH_REGS,
  parameter int PHYS_N  = rename_pkg::PHYS_REGS,
  parameter int GROUP_N = rename_pkg::GROUP_W,
  localparam int PW = $clog2(PHYS_N),
  localparam int CW = $clog2(PHYS_N + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [GROUP_N-1:0]    pop_en,
  output logic [GROUP_N*PW-1:0] pop_tag,
  input  logic [GROUP_N-1:0]    push_en,
  input  logic [GROUP_N*PW-1:0] push_tag,
  output logic [CW-1:0]         count
);
  // Queue depth equals PHYS_N (a power of two), so pointers wrap by overflow.
  logic [PW-1:0] mem [PHYS_N];
  logic [PW-1:0] head, tail;
  logic [PW-1:0] push_off [GROUP_N];
  logic [CW-1:0] pop_n, push_n;

  always_comb begin
    pop_n  = '0;
    push_n = '0;
    for (int j = 0; j < GROUP_N; j++) begin
      push_off[j] = push_n[PW-1:0];
      pop_tag[j*PW +: PW] = mem[head + pop_n[PW-1:0]];
      pop_n  = pop_n + CW'(pop_en[j]);
      push_n = push_n + CW'(push_en[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS_N; i++)
        mem[i] <= (i < PHYS_N - ARCH_N) ? PW'(ARCH_N + i) : '0;
      head  <= '0;
      tail  <= PW'(PHYS_N - ARCH_N);
      count <= CW'(PHYS_N - ARCH_N);
    end else begin
      for (int j = 0; j < GROUP_N; j++)
        if (push_en[j]) mem[tail + push_off[j]] <= push_tag[j*PW +: PW];
      head  <= head + pop_n[PW-1:0];
      tail  <= tail + push_n[PW-1:0];
      count <= count - pop_n + push_n;
    end
  end

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop_n <= count);
  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(PHYS_N));
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int ARCH_N  = rename_pkg::ARCH_REGS,
  parameter int PHYS_N  = rename_pkg::PHYS_REGS,
  parameter int GROUP_N = rename_pkg::GROUP_W,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [GROUP_N-1:0]    wr_en,
  input  logic [GROUP_N*AW-1:0] wr_arch,
  input  logic [GROUP_N*PW-1:0] wr_tag,
  input  logic                  set_en,
  input  logic [PW-1:0]         set_tag,
  output logic [ARCH_N*PW-1:0]  map_flat,
  output logic [ARCH_N-1:0]     rdy_flat
);
  logic [PW-1:0] map_q [ARCH_N];
  logic          rdy_q [ARCH_N];
  logic [ARCH_N-1:0] wr_hit;

  for (genvar e = 0; e < ARCH_N; e++) begin : g_entry
    always_comb begin
      wr_hit[e] = 1'b0;
      for (int j = 0; j < GROUP_N; j++)
        if (wr_en[j] && wr_arch[j*AW +: AW] == AW'(e)) wr_hit[e] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        map_q[e] <= PW'(e);
        rdy_q[e] <= 1'b1;
      end else begin
        if (set_en && map_q[e] == set_tag) rdy_q[e] <= 1'b1;
        // Ascending slot order: the youngest writer lands last.
        for (int j = 0; j < GROUP_N; j++)
          if (wr_en[j] && wr_arch[j*AW +: AW] == AW'(e)) begin
            map_q[e] <= wr_tag[j*PW +: PW];
            rdy_q[e] <= 1'b0;
          end
      end
    end

    assign map_flat[e*PW +: PW] = map_q[e];
    assign rdy_flat[e]          = rdy_q[e];

    // R8
    wake_sets_chk: assert property (@(posedge clk) disable iff (rst)
      (set_en && map_q[e] == set_tag && !wr_hit[e]) |=> rdy_q[e]);
    // R7
    new_entry_clear_chk: assert property (@(posedge clk) disable iff (rst)
      wr_hit[e] |=> !rdy_q[e]);
  end
endmodule

// File: rtl/rename_dep_check.sv
module rename_dep_check #(
  parameter int ARCH_N  = rename_pkg::ARCH_REGS,
  parameter int PHYS_N  = rename_pkg::PHYS_REGS,
  parameter int GROUP_N = rename_pkg::GROUP_W,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic [GROUP_N-1:0]    slot_en,
  input  logic [GROUP_N*AW-1:0] dst,
  input  logic [GROUP_N*AW-1:0] src1,
  input  logic [GROUP_N*AW-1:0] src2,
  input  logic [GROUP_N*PW-1:0] new_tag,
  input  logic [ARCH_N*PW-1:0]  map_flat,
  input  logic [ARCH_N-1:0]     rdy_flat,
  input  logic                  set_en,
  input  logic [PW-1:0]         set_tag,
  output logic [GROUP_N*PW-1:0] src1_tag,
  output logic [GROUP_N*PW-1:0] src2_tag,
  output logic [GROUP_N-1:0]    src1_rdy,
  output logic [GROUP_N-1:0]    src2_rdy,
  output logic [GROUP_N*PW-1:0] prev_tag
);
  always_comb begin
    for (int j = 0; j < GROUP_N; j++) begin
      logic [AW-1:0] a1, a2, ad;
      logic [PW-1:0] t1, t2, tp;
      logic          r1, r2;
      a1 = src1[j*AW +: AW];
      a2 = src2[j*AW +: AW];
      ad = dst[j*AW +: AW];
      t1 = map_flat[a1*PW +: PW];
      t2 = map_flat[a2*PW +: PW];
      tp = map_flat[ad*PW +: PW];
      // A wakeup in this cycle is forwarded so the reader cannot miss it.
      r1 = rdy_flat[a1] | (set_en && t1 == set_tag);
      r2 = rdy_flat[a2] | (set_en && t2 == set_tag);
      for (int i = 0; i < j; i++) begin
        if (slot_en[i] && dst[i*AW +: AW] == a1) begin
          t1 = new_tag[i*PW +: PW];
          r1 = 1'b0;
        end
        if (slot_en[i] && dst[i*AW +: AW] == a2) begin
          t2 = new_tag[i*PW +: PW];
          r2 = 1'b0;
        end
        if (slot_en[i] && dst[i*AW +: AW] == ad) tp = new_tag[i*PW +: PW];
      end
      src1_tag[j*PW +: PW] = t1;
      src2_tag[j*PW +: PW] = t2;
      src1_rdy[j]          = r1;
      src2_rdy[j]          = r2;
      prev_tag[j*PW +: PW] = tp;
    end
  end
endmodule

// File: rtl/rename_stage.sv
module rename_stage #(
  parameter int ARCH_N  = rename_pkg::ARCH_REGS,
  parameter int PHYS_N  = rename_pkg::PHYS_REGS,
  parameter int GROUP_N = rename_pkg::GROUP_W,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N),
  localparam int CW = $clog2(PHYS_N + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [GROUP_N-1:0]    in_valid,
  input  logic [GROUP_N*AW-1:0] in_dst,
  input  logic [GROUP_N*AW-1:0] in_src1,
  input  logic [GROUP_N*AW-1:0] in_src2,
  input  logic [GROUP_N-1:0]    rel_valid,
  input  logic [GROUP_N*PW-1:0] rel_tag,
  input  logic                  wake_valid,
  input  logic [PW-1:0]         wake_tag,
  output logic                  stall,
  output logic [GROUP_N-1:0]    out_valid,
  output logic [GROUP_N*PW-1:0] out_dst_tag,
  output logic [GROUP_N*PW-1:0] out_prev_tag,
  output logic [GROUP_N*PW-1:0] out_src1_tag,
  output logic [GROUP_N*PW-1:0] out_src2_tag,
  output logic [GROUP_N-1:0]    out_src1_ready,
  output logic [GROUP_N-1:0]    out_src2_ready
);
  logic [GROUP_N-1:0]    grant;
  logic [CW-1:0]         free_cnt;
  logic [GROUP_N*PW-1:0] alloc_tag, s1_tag, s2_tag, pv_tag;
  logic [GROUP_N-1:0]    s1_rdy, s2_rdy;
  logic [ARCH_N*PW-1:0]  map_flat;
  logic [ARCH_N-1:0]     rdy_flat;

  assign stall = $countones(in_valid) > int'(free_cnt);
  assign grant = stall ? '0 : in_valid;

  rename_free_list #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .GROUP_N(GROUP_N)) u_free (
    .clk(clk), .rst(rst), .pop_en(grant), .pop_tag(alloc_tag),
    .push_en(rel_valid), .push_tag(rel_tag), .count(free_cnt));

  rename_map_table #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .GROUP_N(GROUP_N)) u_map (
    .clk(clk), .rst(rst), .wr_en(grant), .wr_arch(in_dst), .wr_tag(alloc_tag),
    .set_en(wake_valid), .set_tag(wake_tag), .map_flat(map_flat), .rdy_flat(rdy_flat));

  rename_dep_check #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .GROUP_N(GROUP_N)) u_dep (
    .slot_en(grant), .dst(in_dst), .src1(in_src1), .src2(in_src2),
    .new_tag(alloc_tag), .map_flat(map_flat), .rdy_flat(rdy_flat),
    .set_en(wake_valid), .set_tag(wake_tag),
    .src1_tag(s1_tag), .src2_tag(s2_tag), .src1_rdy(s1_rdy), .src2_rdy(s2_rdy),
    .prev_tag(pv_tag));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= '0;
      out_dst_tag    <= '0;
      out_prev_tag   <= '0;
      out_src1_tag   <= '0;
      out_src2_tag   <= '0;
      out_src1_ready <= '0;
      out_src2_ready <= '0;
    end else begin
      out_valid      <= grant;
      out_dst_tag    <= alloc_tag;
      out_prev_tag   <= pv_tag;
      out_src1_tag   <= s1_tag;
      out_src2_tag   <= s2_tag;
      out_src1_ready <= s1_rdy;
      out_src2_ready <= s2_rdy;
    end
  end

  // R9
  stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (out_valid == '0));
  // R11
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (out_valid == $past(in_valid)));
  // R4
  raw_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (grant[0] && grant[1] && in_dst[AW-1:0] == in_src1[AW +: AW])
    |=> (out_src1_tag[PW +: PW] == out_dst_tag[PW-1:0] && !out_src1_ready[1]));
endmodule

// File: tb/rename_stage_tb.sv
module rename_stage_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  in_valid;
  logic [15:0] in_dst, in_src1, in_src2;
  logic [3:0]  rel_valid;
  logic [27:0] rel_tag;
  logic        wake_valid;
  logic [6:0]  wake_tag;
  logic        stall;
  logic [3:0]  out_valid, out_src1_ready, out_src2_ready;
  logic [27:0] out_dst_tag, out_prev_tag, out_src1_tag, out_src2_tag;

  rename_stage u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst), .in_src1(in_src1),
    .in_src2(in_src2), .rel_valid(rel_valid), .rel_tag(rel_tag),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .stall(stall),
    .out_valid(out_valid), .out_dst_tag(out_dst_tag), .out_prev_tag(out_prev_tag),
    .out_src1_tag(out_src1_tag), .out_src2_tag(out_src2_tag),
    .out_src1_ready(out_src1_ready), .out_src2_ready(out_src2_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  // Stimulus for the next group.
  bit v[4]; int d[4], s1[4], s2[4]; bit rv[4]; int rt[4]; bit wv; int wt;
  // Reference model from the requirements.
  int mmap[16]; bit mrdy[16]; int fq[256]; int fh, ft, fc;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int j = 0; j < 4; j++) begin
      v[j] = 0; d[j] = 0; s1[j] = 0; s2[j] = 0; rv[j] = 0; rt[j] = 0;
    end
    wv = 0; wt = 0;
  endtask

  task automatic drive_idle();
    in_valid = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
    rel_valid = '0; rel_tag = '0; wake_valid = 1'b0; wake_tag = '0;
  endtask

  // One cycle: called at a falling edge; checks at the next falling edge.
  task automatic step(input string req);
    int need; bit es; bit ev[4];
    int ed[4], ep[4], e1[4], e2[4]; bit r1[4], r2[4];
    for (int j = 0; j < 4; j++) begin
      in_valid[j] = v[j];
      in_dst[j*4 +: 4] = 4'(d[j]); in_src1[j*4 +: 4] = 4'(s1[j]); in_src2[j*4 +: 4] = 4'(s2[j]);
      rel_valid[j] = rv[j]; rel_tag[j*7 +: 7] = 7'(rt[j]);
    end
    wake_valid = wv; wake_tag = 7'(wt);
    #1;
    need = 0;
    for (int j = 0; j < 4; j++) need += int'(v[j]);
    es = fc < need;
    check("R9", "stall", int'(stall), int'(es));
    if (wv) for (int a = 0; a < 16; a++) if (mmap[a] == wt) mrdy[a] = 1;
    for (int j = 0; j < 4; j++) begin
      ev[j] = v[j] && !es;
      if (ev[j]) begin
        e1[j] = mmap[s1[j]]; r1[j] = mrdy[s1[j]];
        e2[j] = mmap[s2[j]]; r2[j] = mrdy[s2[j]];
        ep[j] = mmap[d[j]];
        ed[j] = fq[fh % 256]; fh++; fc--;
        mmap[d[j]] = ed[j]; mrdy[d[j]] = 0;
      end
    end
    for (int j = 0; j < 4; j++) if (rv[j]) begin fq[ft % 256] = rt[j]; ft++; fc++; end
    @(posedge clk); #1;
    drive_idle();
    @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      check("R11", "out_valid bit", int'(out_valid[j]), int'(ev[j]));
      if (ev[j]) begin
        check(req, "dst tag", int'(out_dst_tag[j*7 +: 7]), ed[j]);
        check(req, "prev tag", int'(out_prev_tag[j*7 +: 7]), ep[j]);
        check(req, "src1 tag", int'(out_src1_tag[j*7 +: 7]), e1[j]);
        check(req, "src2 tag", int'(out_src2_tag[j*7 +: 7]), e2[j]);
        check(req, "src1 ready", int'(out_src1_ready[j]), int'(r1[j]));
        check(req, "src2 ready", int'(out_src2_ready[j]), int'(r2[j]));
      end
    end
    clear_stim();
  endtask

  // R1: fresh identity mapping, all ready
  task automatic t_reset();
    check("R1", "out_valid after reset", int'(out_valid), 0);
    for (int j = 0; j < 4; j++) begin v[j] = 1; d[j] = 8 + j; s1[j] = j; s2[j] = 4 + j; end
    step("R1");
  endtask

  // R2/R3/R6: plain allocation, then the table shows the new mappings
  task automatic t_alloc();
    for (int j = 0; j < 4; j++) begin v[j] = 1; d[j] = 1 + j; s1[j] = 12; s2[j] = 13; end
    step("R2");
    for (int j = 0; j < 4; j++) begin v[j] = 1; d[j] = 14; s1[j] = 1 + j; s2[j] = 8 + j; end
    step("R3");
  endtask

  // R4/R7: chain of reads of older same-group writes
  task automatic t_chain();
    v = '{1, 1, 1, 1};
    d = '{5, 6, 9, 10}; s1 = '{0, 5, 6, 9}; s2 = '{15, 15, 5, 6};
    step("R4");
    v = '{1, 1, 0, 0}; d = '{0, 0, 0, 0}; s1 = '{10, 9, 0, 0}; s2 = '{6, 5, 0, 0};
    step("R7");
  endtask

  // R5/R6: every slot writes the same register
  task automatic t_waw();
    v = '{1, 1, 1, 1}; d = '{7, 7, 7, 7}; s1 = '{7, 7, 7, 7}; s2 = '{3, 7, 3, 7};
    step("R6");
    v = '{1, 0, 0, 0}; d = '{11, 0, 0, 0}; s1 = '{7, 0, 0, 0}; s2 = '{7, 0, 0, 0};
    step("R5");
  endtask

  // R2: sparse slots consume tags only for the valid ones
  task automatic t_sparse();
    v = '{0, 1, 0, 1}; d = '{2, 3, 4, 3}; s1 = '{1, 3, 1, 3}; s2 = '{2, 2, 2, 2};
    step("R2");
  endtask

  // R8: same-cycle wakeup forwarding, then a persisted ready flag
  task automatic t_wake();
    v = '{1, 0, 0, 0}; d = '{12, 0, 0, 0}; s1 = '{7, 0, 0, 0}; s2 = '{3, 0, 0, 0};
    wv = 1; wt = mmap[7];
    step("R8");
    v = '{1, 1, 0, 0}; d = '{13, 15, 0, 0}; s1 = '{7, 12, 0, 0}; s2 = '{3, 7, 0, 0};
    wv = 1; wt = 127;
    step("R8");
  endtask

  // R9/R10: drain the queue, stall, release on scattered lanes, refill
  task automatic t_drain();
    int k; k = 0;
    while (fc >= 4) begin
      for (int j = 0; j < 4; j++) begin v[j] = 1; d[j] = (k + j) % 16; s1[j] = (k + 2*j) % 16; s2[j] = j; end
      k++;
      step("R2");
    end
    for (int j = 0; j <= fc && j < 4; j++) begin v[j] = 1; d[j] = j; s1[j] = j + 1; s2[j] = 2; end
    step("R9");
    for (int j = 0; j <= fc && j < 4; j++) begin v[j] = 1; d[j] = j; s1[j] = 3; s2[j] = j; end
    rv = '{1, 0, 1, 1}; rt = '{100, 0, 101, 102};
    step("R10");
    for (int j = 0; j < fc && j < 4; j++) begin v[j] = 1; d[j] = 4 + j; s1[j] = 4; s2[j] = 5; end
    step("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 16; a++) begin mmap[a] = a; mrdy[a] = 1; end
    for (int i = 0; i < 112; i++) fq[i] = 16 + i;
    fh = 0; ft = 112; fc = 112;
    clear_stim();
    drive_idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alloc();
    t_chain();
    t_waw();
    t_sparse();
    t_wake();
    t_drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule